// File: doc/BRIEF.md
# ATA Software-Reset and Device Signature Probe

This block is a host-side sequencer that resets an ATA bus and classifies a device on it. When it is started, it pulses the software-reset bit in the bus's control register, reads alternate status a fixed number of times so the drives can settle, and then polls until status shows a drive that is no longer busy and is ready. It then selects master or slave, waits another settle period, reads the two cylinder registers and turns that pair of bytes into a device-type code. The code tells a parallel ATA disk, a serial ATA disk, a parallel packet device and a serial packet device apart.

The block drives a one-cycle task-file access port: one read or write strobe per cycle, a flag that chooses the control block or the command block, a three-bit register offset and a write byte. The read byte is sampled in the same cycle as the read strobe. In the control block, offset 6 is the device-control register on writes and alternate status on reads. The settle time (`SETTLE_READS` status reads, standing in for a 400 ns wait) and the poll budget (`POLL_LIMIT` reads) are parameters.

Top module: `ata_sig_probe`

## Requirements
- R1: After reset, done_o, timeout_o and tf_rd_o/tf_wr_o are 0 and dev_type_o is 0 (unknown).
- R2: A start taken while idle writes 0x04 to control-block offset 6 and, in the next cycle, writes 0x00 to the same place. Every control-block write has all bits other than bit 2 clear, and read and write are never asserted together.
- R3: After the reset bit is cleared, exactly SETTLE_READS alternate-status reads (control block, offset 6) are made and their values are ignored. Polling starts only after them.
- R4: A poll read counts as ready only when (status AND 0xC0) == 0x40, that is, bit 7 (busy) is clear and bit 6 (ready) is set. All other bits are ignored.
- R5: On the first ready poll, the block writes 0xA0 | (slave << 4) to command-block offset 6. The slave bit is the value of slave_i captured with the start.
- R6: After the select write, exactly SETTLE_READS alternate-status reads are made. The block then reads command-block offset 4 (cylinder low) and reads offset 5 (cylinder high) in the next cycle.
- R7: Low/high pairs are decoded as follows: 0x00/0x00 gives code 1 (parallel ATA), 0x14/0xEB gives code 2 (parallel packet), 0x3C/0xC3 gives code 3 (serial ATA) and 0x69/0x96 gives code 4 (serial packet). done_o is set with timeout_o clear.
- R8: Any other low/high pair gives code 0 (unknown), with done_o set and timeout_o clear.
- R9: If POLL_LIMIT poll reads in a row are not ready, the block sets done_o and timeout_o, reports code 0, and makes no select write and no cylinder reads.
- R10: done_o, timeout_o and dev_type_o keep their values until the next start. The start clears all three in the following cycle.
- R11: A start pulse that arrives while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a reset-and-classify run when the block is idle |
| slave_i | input | 1 | Drive to classify: 0 master, 1 slave; captured at start |
| tf_rd_o | output | 1 | Task-file read strobe, one cycle per access |
| tf_wr_o | output | 1 | Task-file write strobe, one cycle per access |
| tf_ctl_o | output | 1 | 1 selects the control block, 0 the command block |
| tf_reg_o | output | 3 | Register offset within the selected block |
| tf_wdata_o | output | 8 | Write byte |
| tf_rdata_i | input | 8 | Read byte, valid in the cycle of tf_rd_o |
| done_o | output | 1 | Run finished; held until the next start |
| timeout_o | output | 1 | Ready-wait expired; held until the next start |
| dev_type_o | output | 3 | Device-type code; held until the next start |

## Verification
Several status patterns are applied. Some drives report ready already during the settle reads; a design that polled too early would select after fewer than SETTLE_READS+1 status reads. Some drives report busy together with ready, and one reports neither. A design that tested only one bit would select while the drive is still busy, or would accept a drive that is not ready. A ready value with extra bits set (data request, error) must still be accepted.

Master and slave carry different signatures. A slave bit that is not latched, or is flipped during the run, then shows up as the wrong code. A second start during a run would show as a second reset write. A value that does not match any pair must decode as unknown. A drive that stays busy must end after exactly POLL_LIMIT polls, with no select write.

// File: rtl/ata_sig_pkg.sv
package ata_sig_pkg;

    typedef enum logic [2:0] {
        DEV_UNKNOWN = 3'd0,
        DEV_PATA    = 3'd1,
        DEV_PATAPI  = 3'd2,
        DEV_SATA    = 3'd3,
        DEV_SATAPI  = 3'd4
    } dev_type_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RST_SET,
        PH_RST_CLR,
        PH_SETTLE_A,
        PH_POLL,
        PH_SELECT,
        PH_SETTLE_B,
        PH_SIG_LO,
        PH_SIG_HI
    } phase_e;

    // register offsets
    localparam logic [2:0] OFS_CTL_ALT = 3'd6;  // control block: control / alt status
    localparam logic [2:0] OFS_DRVSEL  = 3'd6;  // command block: drive select
    localparam logic [2:0] OFS_CYL_LO  = 3'd4;
    localparam logic [2:0] OFS_CYL_HI  = 3'd5;

    // control and status encodings
    localparam logic [7:0] CTL_RESET_ON = 8'h04;
    localparam logic [7:0] CTL_QUIET    = 8'h00;
    localparam logic [7:0] STAT_MASK    = 8'hC0;
    localparam logic [7:0] STAT_READY   = 8'h40;
    localparam logic [7:0] SEL_BASE     = 8'hA0;

    // signature byte pairs
    localparam logic [7:0] SIG_PATAPI_LO = 8'h14;
    localparam logic [7:0] SIG_PATAPI_HI = 8'hEB;
    localparam logic [7:0] SIG_SATAPI_LO = 8'h69;
    localparam logic [7:0] SIG_SATAPI_HI = 8'h96;
    localparam logic [7:0] SIG_SATA_LO   = 8'h3C;
    localparam logic [7:0] SIG_SATA_HI   = 8'hC3;

    typedef struct packed {
        phase_e    phase;
        logic      slave;
        logic [7:0] sig_lo;
        logic      done;
        logic      tmo;
        dev_type_e dtype;
    } probe_state_s;

endpackage

// File: rtl/ata_sig_wait.sv
module ata_sig_wait #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         last_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (dec_i)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == '0);

    // R3: the sequencer never steps the counter below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));

    // R3: load and step are never requested together
    p_load_step_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && dec_i));

endmodule

// File: rtl/ata_sig_decode.sv
module ata_sig_decode
    import ata_sig_pkg::*;
(
    input  logic [7:0] lo_i,
    input  logic [7:0] hi_i,
    output dev_type_e  type_o
);
    always_comb begin
        if (lo_i == 8'h00 && hi_i == 8'h00)
            type_o = DEV_PATA;
        else if (lo_i == SIG_PATAPI_LO && hi_i == SIG_PATAPI_HI)
            type_o = DEV_PATAPI;
        else if (lo_i == SIG_SATA_LO && hi_i == SIG_SATA_HI)
            type_o = DEV_SATA;
        else if (lo_i == SIG_SATAPI_LO && hi_i == SIG_SATAPI_HI)
            type_o = DEV_SATAPI;
        else
            type_o = DEV_UNKNOWN;
    end

    // R8: unknown is produced only when no signature pair matches
    always_comb begin
        if (type_o == DEV_UNKNOWN)
            a_unknown_nomatch_r8: assert (!(lo_i == 8'h00 && hi_i == 8'h00));
    end

endmodule

// File: rtl/ata_sig_probe.sv
module ata_sig_probe
    import ata_sig_pkg::*;
#(
    parameter int SETTLE_READS = 4,
    parameter int POLL_LIMIT   = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       slave_i,
    output logic       tf_rd_o,
    output logic       tf_wr_o,
    output logic       tf_ctl_o,
    output logic [2:0] tf_reg_o,
    output logic [7:0] tf_wdata_o,
    input  logic [7:0] tf_rdata_i,
    output logic       done_o,
    output logic       timeout_o,
    output logic [2:0] dev_type_o
);
    localparam int MAXV = (SETTLE_READS > POLL_LIMIT) ? SETTLE_READS : POLL_LIMIT;
    localparam int CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_READS - 1);
    localparam logic [CW-1:0] POLL_LD   = CW'(POLL_LIMIT - 1);

    probe_state_s st_d, st_q;

    logic          cnt_load, cnt_dec, cnt_last;
    logic [CW-1:0] cnt_val;
    dev_type_e     sig_type;
    logic          stat_ready;

    ata_sig_wait #(.W(CW)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (cnt_val),
        .dec_i  (cnt_dec),
        .last_o (cnt_last)
    );

    ata_sig_decode u_decode (
        .lo_i   (st_q.sig_lo),
        .hi_i   (tf_rdata_i),
        .type_o (sig_type)
    );

    assign stat_ready = ((tf_rdata_i & STAT_MASK) == STAT_READY);

    always_comb begin
        st_d       = st_q;
        cnt_load   = 1'b0;
        cnt_dec    = 1'b0;
        cnt_val    = '0;
        tf_rd_o    = 1'b0;
        tf_wr_o    = 1'b0;
        tf_ctl_o   = 1'b0;
        tf_reg_o   = '0;
        tf_wdata_o = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RST_SET;
                    st_d.slave = slave_i;
                    st_d.done  = 1'b0;
                    st_d.tmo   = 1'b0;
                    st_d.dtype = DEV_UNKNOWN;
                end
            end
            PH_RST_SET: begin
                tf_wr_o    = 1'b1;
                tf_ctl_o   = 1'b1;
                tf_reg_o   = OFS_CTL_ALT;
                tf_wdata_o = CTL_RESET_ON;
                st_d.phase = PH_RST_CLR;
            end
            PH_RST_CLR: begin
                tf_wr_o    = 1'b1;
                tf_ctl_o   = 1'b1;
                tf_reg_o   = OFS_CTL_ALT;
                tf_wdata_o = CTL_QUIET;
                cnt_load   = 1'b1;
                cnt_val    = SETTLE_LD;
                st_d.phase = PH_SETTLE_A;
            end
            PH_SETTLE_A: begin
                tf_rd_o  = 1'b1;
                tf_ctl_o = 1'b1;
                tf_reg_o = OFS_CTL_ALT;
                if (cnt_last) begin
                    cnt_load   = 1'b1;
                    cnt_val    = POLL_LD;
                    st_d.phase = PH_POLL;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            PH_POLL: begin
                tf_rd_o  = 1'b1;
                tf_ctl_o = 1'b1;
                tf_reg_o = OFS_CTL_ALT;
                if (stat_ready) begin
                    st_d.phase = PH_SELECT;
                end else if (cnt_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.tmo   = 1'b1;
                    st_d.dtype = DEV_UNKNOWN;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            PH_SELECT: begin
                tf_wr_o    = 1'b1;
                tf_reg_o   = OFS_DRVSEL;
                tf_wdata_o = SEL_BASE | {3'b000, st_q.slave, 4'b0000};
                cnt_load   = 1'b1;
                cnt_val    = SETTLE_LD;
                st_d.phase = PH_SETTLE_B;
            end
            PH_SETTLE_B: begin
                tf_rd_o  = 1'b1;
                tf_ctl_o = 1'b1;
                tf_reg_o = OFS_CTL_ALT;
                if (cnt_last)
                    st_d.phase = PH_SIG_LO;
                else
                    cnt_dec = 1'b1;
            end
            PH_SIG_LO: begin
                tf_rd_o     = 1'b1;
                tf_reg_o    = OFS_CYL_LO;
                st_d.sig_lo = tf_rdata_i;
                st_d.phase  = PH_SIG_HI;
            end
            PH_SIG_HI: begin
                tf_rd_o    = 1'b1;
                tf_reg_o   = OFS_CYL_HI;
                st_d.dtype = sig_type;
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.slave  <= 1'b0;
            st_q.sig_lo <= '0;
            st_q.done   <= 1'b0;
            st_q.tmo    <= 1'b0;
            st_q.dtype  <= DEV_UNKNOWN;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o     = st_q.done;
    assign timeout_o  = st_q.tmo;
    assign dev_type_o = st_q.dtype;

    // R2: strobes never overlap
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tf_rd_o && tf_wr_o));

    // R2: the reset write is followed at once by the clearing write
    p_reset_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_wr_o && tf_ctl_o && tf_wdata_o == CTL_RESET_ON)
        |=> (tf_wr_o && tf_ctl_o && tf_wdata_o == CTL_QUIET));

    // R2: control writes carry nothing besides the reset bit
    p_ctl_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_wr_o && tf_ctl_o) |-> ((tf_wdata_o & 8'hFB) == 8'h00));

    // R5: drive select carries the latched drive bit
    p_select_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_wr_o && !tf_ctl_o) |-> (tf_reg_o == OFS_DRVSEL &&
                                    tf_wdata_o == (SEL_BASE | {3'b000, st_q.slave, 4'b0000})));

    // R6: high signature byte is read right after the low one
    p_sig_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_rd_o && !tf_ctl_o && tf_reg_o == OFS_CYL_LO)
        |=> (tf_rd_o && !tf_ctl_o && tf_reg_o == OFS_CYL_HI));

    // R9: a timeout always comes with an unknown code
    p_timeout_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (done_o && dev_type_o == DEV_UNKNOWN));

    // R10: results are held while no start arrives
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(dev_type_o) && $stable(timeout_o)));

endmodule

// File: tb/ata_sig_probe_bench.sv
module ata_sig_probe_bench;
    localparam int B_SETTLE = 4;
    localparam int B_LIMIT  = 1000;
    localparam int WD_CYC   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       slave = 1'b0;
    logic       tf_rd, tf_wr, tf_ctl;
    logic [2:0] tf_reg;
    logic [7:0] tf_wdata, tf_rdata;
    logic       done, tmo;
    logic [2:0] dtype;

    always #10 clk = ~clk;

    ata_sig_probe #(.SETTLE_READS(B_SETTLE), .POLL_LIMIT(B_LIMIT)) u_ata_sig_probe (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .slave_i    (slave),
        .tf_rd_o    (tf_rd),
        .tf_wr_o    (tf_wr),
        .tf_ctl_o   (tf_ctl),
        .tf_reg_o   (tf_reg),
        .tf_wdata_o (tf_wdata),
        .tf_rdata_i (tf_rdata),
        .done_o     (done),
        .timeout_o  (tmo),
        .dev_type_o (dtype)
    );

    // device model configuration (written by tasks)
    int         m_busy_n = 0;
    logic [7:0] m_busy_val = 8'h80;
    logic [7:0] m_ready_val = 8'h50;
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    // device model state and monitor (written by the monitor only)
    int         m_rd_cnt;
    logic       m_dev;
    logic       clr_req = 1'b0;
    int         n_set, n_clr, n_alt, n_sel, n_lo, n_hi, n_wr, n_badctl;
    int         alt_at_sel, alt_at_lo, cyc_lo, cyc_hi;
    logic [7:0] sel_val;
    logic       w_ctl [8];
    logic [7:0] w_dat [8];
    int         cyc = 0;

    int n_checks = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always_comb begin
        tf_rdata = 8'h00;
        if (tf_ctl && tf_reg == 3'd6)
            tf_rdata = (m_rd_cnt < m_busy_n) ? m_busy_val : m_ready_val;
        else if (!tf_ctl && tf_reg == 3'd4)
            tf_rdata = m_lo[m_dev];
        else if (!tf_ctl && tf_reg == 3'd5)
            tf_rdata = m_hi[m_dev];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr_req) begin
            n_set <= 0; n_clr <= 0; n_alt <= 0; n_sel <= 0; n_lo <= 0; n_hi <= 0;
            n_wr <= 0; n_badctl <= 0; alt_at_sel <= -1; alt_at_lo <= -1;
            cyc_lo <= -1; cyc_hi <= -1; sel_val <= 8'h00; m_rd_cnt <= 0; m_dev <= 1'b0;
        end else begin
            if (tf_wr) begin
                if (n_wr < 8) begin
                    w_ctl[n_wr] <= tf_ctl;
                    w_dat[n_wr] <= tf_wdata;
                end
                n_wr <= n_wr + 1;
            end
            if (tf_wr && tf_ctl) begin
                if (tf_reg != 3'd6 || (tf_wdata != 8'h04 && tf_wdata != 8'h00))
                    n_badctl <= n_badctl + 1;
                if (tf_wdata == 8'h04) begin
                    n_set    <= n_set + 1;
                    m_rd_cnt <= 0;
                    m_dev    <= 1'b0;
                end else begin
                    n_clr <= n_clr + 1;
                end
            end
            if (tf_wr && !tf_ctl && tf_reg == 3'd6) begin
                m_dev      <= tf_wdata[4];
                n_sel      <= n_sel + 1;
                sel_val    <= tf_wdata;
                alt_at_sel <= n_alt;
            end
            if (tf_rd && tf_ctl && tf_reg == 3'd6) begin
                m_rd_cnt <= m_rd_cnt + 1;
                n_alt    <= n_alt + 1;
            end
            if (tf_rd && !tf_ctl && tf_reg == 3'd4) begin
                n_lo      <= n_lo + 1;
                alt_at_lo <= n_alt;
                cyc_lo    <= cyc;
            end
            if (tf_rd && !tf_ctl && tf_reg == 3'd5) begin
                n_hi   <= n_hi + 1;
                cyc_hi <= cyc;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) clr_req = 1'b1;
        @(negedge clk) clr_req = 1'b0;
    endtask

    task automatic pulse_start(input logic sl);
        @(negedge clk);
        start = 1'b1;
        slave = sl;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        check(done, "R7 run completes", done, 1);
    endtask

    task automatic set_dev(input logic [7:0] mlo, input logic [7:0] mhi,
                           input logic [7:0] slo, input logic [7:0] shi,
                           input int busy_n, input logic [7:0] bval, input logic [7:0] rval);
        m_lo[0] = mlo; m_hi[0] = mhi;
        m_lo[1] = slo; m_hi[1] = shi;
        m_busy_n = busy_n; m_busy_val = bval; m_ready_val = rval;
    endtask

    task automatic check_run(input string req, input logic sl, input int busy_n,
                             input int exp_type);
        int exp_sel_alt;
        exp_sel_alt = (busy_n > B_SETTLE) ? busy_n + 1 : B_SETTLE + 1;
        check(n_set == 1 && n_clr == 1 && n_badctl == 0, "R2 one reset pulse", n_set, 1);
        check(w_ctl[0] == 1'b1 && w_dat[0] == 8'h04, "R2 first write sets reset bit", w_dat[0], 8'h04);
        check(w_ctl[1] == 1'b1 && w_dat[1] == 8'h00, "R2 second write clears", w_dat[1], 8'h00);
        check(n_sel == 1 && w_ctl[2] == 1'b0, "R5 one select write", n_sel, 1);
        check(sel_val == (8'hA0 | {3'b000, sl, 4'b0000}), "R5 select value", sel_val,
              8'hA0 | {3'b000, sl, 4'b0000});
        check(alt_at_sel == exp_sel_alt, {req, " R3 R4 status reads before select"},
              alt_at_sel, exp_sel_alt);
        check(alt_at_lo == exp_sel_alt + B_SETTLE, "R6 settle after select",
              alt_at_lo, exp_sel_alt + B_SETTLE);
        check(n_lo == 1 && n_hi == 1 && cyc_hi == cyc_lo + 1, "R6 low then high read",
              cyc_hi - cyc_lo, 1);
        check(int'(dtype) == exp_type && !tmo, {req, " device code"}, dtype, exp_type);
    endtask

    task automatic t_reset();
        check(!done && !tmo && dtype == 3'd0, "R1 reset outputs", {done, tmo, dtype}, 0);
        check(!tf_rd && !tf_wr, "R1 no strobes", {tf_rd, tf_wr}, 0);
    endtask

    task automatic t_classify(input string req, input logic sl,
                              input logic [7:0] mlo, input logic [7:0] mhi,
                              input logic [7:0] slo, input logic [7:0] shi,
                              input int busy_n, input logic [7:0] bval, input logic [7:0] rval,
                              input int exp_type);
        set_dev(mlo, mhi, slo, shi, busy_n, bval, rval);
        clear_mon();
        pulse_start(sl);
        wait_done();
        check_run(req, sl, busy_n, exp_type);
    endtask

    task automatic t_ignore_restart();
        set_dev(8'h00, 8'h00, 8'h3C, 8'hC3, 3, 8'h80, 8'h50);
        clear_mon();
        pulse_start(1'b0);
        repeat (3) @(negedge clk);
        slave = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_run("R11 restart ignored, R5 slave latched", 1'b0, 3, 1);
    endtask

    task automatic t_hold();
        set_dev(8'h14, 8'hEB, 8'h00, 8'h00, 0, 8'h80, 8'h50);
        clear_mon();
        pulse_start(1'b0);
        wait_done();
        repeat (20) @(negedge clk);
        check(done && !tmo && dtype == 3'd2, "R10 result held", dtype, 2);
        pulse_start(1'b0);
        check(!done && !tmo && dtype == 3'd0, "R10 start clears result", {done, dtype}, 0);
        wait_done();
        check(dtype == 3'd2, "R10 next run result", dtype, 2);
    endtask

    task automatic t_timeout();
        set_dev(8'h00, 8'h00, 8'h00, 8'h00, 100000, 8'hD0, 8'h50);
        clear_mon();
        pulse_start(1'b0);
        wait_done();
        check(tmo && dtype == 3'd0, "R9 timeout flagged", {tmo, dtype}, 8);
        check(n_alt == B_SETTLE + B_LIMIT, "R9 poll count", n_alt, B_SETTLE + B_LIMIT);
        check(n_sel == 0 && n_lo == 0 && n_hi == 0, "R9 no select or signature read",
              n_sel + n_lo + n_hi, 0);
    endtask

    always @(negedge clk) begin
        if (cyc >= WD_CYC && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_CYC);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        set_dev(8'h00, 8'h00, 8'h00, 8'h00, 0, 8'h80, 8'h50);
        clr_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr_req = 1'b0;
        @(negedge clk);
        t_reset();
        // R7 R3: ready already during settle, master parallel ATA
        t_classify("R7 pata", 1'b0, 8'h00, 8'h00, 8'h14, 8'hEB, 0, 8'h80, 8'h50, 1);
        // R7 R4: busy only, ready value with extra bits, slave parallel packet
        t_classify("R7 patapi", 1'b1, 8'h00, 8'h00, 8'h14, 8'hEB, 6, 8'h80, 8'h58, 2);
        // R4: busy together with ready must not count
        t_classify("R7 sata", 1'b0, 8'h3C, 8'hC3, 8'h00, 8'h00, 8, 8'hD0, 8'h50, 3);
        // R4: neither busy nor ready must not count
        t_classify("R7 satapi", 1'b1, 8'h00, 8'h00, 8'h69, 8'h96, 5, 8'h00, 8'h41, 4);
        // R8: mismatched pair
        t_classify("R8 unknown", 1'b0, 8'h14, 8'hC3, 8'h00, 8'h00, 2, 8'h80, 8'h50, 0);
        t_ignore_restart();
        t_hold();
        t_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule